// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM needs an AUTO REFRESH and takes the command bus to run one. A free-running interval counter forces a refresh every 770 cycles, which is 7.7 us at 100 MHz. That period leaves margin under the 7.8 us per-command limit that follows from refreshing 8192 rows every 64 ms. A manual request input can start a refresh early, and it also restarts the interval counter. Refresh can therefore be packed in right after a long transfer, and the counter still guarantees refresh when the controller sits idle.

The block raises a pending flag whenever a refresh is owed. The transfer engine treats this flag as a stop sign. It starts no new access, and it precharges and returns to idle before it drops its busy status. Once the engine is idle, the scheduler issues the configured number of AUTO REFRESH commands, spaced by the row cycle time. It then pulses a done output. The pending flag stays high for the whole sequence, so no other command can reach the device while the banks are refreshing. Auto refresh needs no address, because the device counts rows itself.

Top module: `sdr_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, ref_pend_o is 0, ref_done_o is 0 and the command pins carry NOP, which is {cs_n,ras_n,cas_n,we_n} = 4'b0111.
- R2: With init_done_i held high and no manual request, ref_pend_o rises on the TIMER_CYCLES-th rising edge, counting the first edge that samples init_done_i high as the first. Further expiries follow every TIMER_CYCLES edges.
- R3: While init_done_i is low, the interval counter is held at its start and manual_req_i is ignored, so ref_pend_o never rises.
- R4: A manual_req_i sampled high while init_done_i is high sets ref_pend_o on that edge. It also restarts the interval counter, so the next timed expiry comes TIMER_CYCLES edges after the request edge.
- R5: No AUTO REFRESH is issued during a cycle that follows an edge sampling xfer_busy_i high. ref_pend_o stays high until the engine reports idle.
- R6: One cycle after an edge that sees the flag pending and xfer_busy_i low, the block issues NUM_AREF AUTO REFRESH commands ({cs_n,ras_n,cas_n,we_n} = 4'b0001). The commands are TRC_CYCLES cycles apart, and every other cycle carries NOP.
- R7: ref_done_o is high for exactly one cycle, TRC_CYCLES cycles after the last AUTO REFRESH. ref_pend_o falls on the following edge unless a new trigger arrives on that same edge.
- R8: A timer expiry or manual request that arrives while a refresh is already pending or running is absorbed. It adds no second refresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Device initialisation complete; enables scheduling |
| manual_req_i | input | 1 | Early refresh request, one cycle |
| xfer_busy_i | input | 1 | Transfer engine not yet back in idle |
| ref_pend_o | output | 1 | Refresh owed or running; blocks new transfers |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| ref_done_o | output | 1 | One-cycle pulse when the refresh sequence ends |

## Verification
The bench holds busy high across a timer expiry and then across a manual request. A scheduler that counts triggers instead of latching them would run an extra sequence afterwards. A manual request lands mid-interval so the bench can confirm the counter restarts; a design that only sets the flag would refresh again too early. Requests before init_done catch a block that refreshes an uninitialised device. Checking every cycle of the command spacing exposes an off-by-one in the gap count, which would violate the row cycle time.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_GAP   = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int unsigned LIMIT = 770
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || restart_i || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdr_ref_pend.sv
module sdr_ref_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set wins: a trigger on the closing edge starts a fresh refresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/sdr_ref_seq.sv
module sdr_ref_seq
  import sdr_ref_pkg::*;
#(
  parameter int unsigned NUM_AREF   = 2,
  parameter int unsigned TRC_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic busy_i,
  output logic issue_o,
  output logic done_o
);
  localparam int unsigned GW = (TRC_CYCLES > 2) ? $clog2(TRC_CYCLES) : 1;
  localparam int unsigned NW = $clog2(NUM_AREF + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(TRC_CYCLES - 2);
  localparam logic [NW-1:0] CMD_LAST = NW'(NUM_AREF - 1);

  seq_state_e    state_q, state_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [NW-1:0] num_q, num_d;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    num_d   = num_q;
    unique case (state_q)
      SEQ_IDLE: begin
        num_d = '0;
        if (pend_i && !busy_i) state_d = SEQ_ISSUE;
      end
      SEQ_ISSUE: begin
        gap_d   = '0;
        state_d = SEQ_GAP;
      end
      SEQ_GAP: begin
        gap_d = gap_q + 1'b1;
        if (gap_q == GAP_LAST) begin
          if (num_q == CMD_LAST) begin
            state_d = SEQ_DONE;
          end else begin
            num_d   = num_q + 1'b1;
            state_d = SEQ_ISSUE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      gap_q   <= '0;
      num_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      num_q   <= num_d;
    end
  end

  assign issue_o = (state_q == SEQ_ISSUE);
  assign done_o  = (state_q == SEQ_DONE);
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
  import sdr_ref_pkg::*;
#(
  parameter int unsigned TIMER_CYCLES = 770,
  parameter int unsigned NUM_AREF     = 2,
  parameter int unsigned TRC_CYCLES   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic manual_req_i,
  input  logic xfer_busy_i,
  output logic ref_pend_o,
  output logic sd_cs_n_o,
  output logic sd_ras_n_o,
  output logic sd_cas_n_o,
  output logic sd_we_n_o,
  output logic ref_done_o
);
  logic     man_acc_w, expire_w, trig_w, aref_w, done_w;
  sdr_cmd_t cmd_w;

  assign man_acc_w = init_done_i && manual_req_i;
  assign trig_w    = man_acc_w || expire_w;

  sdr_ref_timer #(.LIMIT(TIMER_CYCLES)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (init_done_i),
    .restart_i (man_acc_w),
    .expire_o  (expire_w)
  );

  sdr_ref_pend pend_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_w),
    .clr_i  (done_w),
    .pend_o (ref_pend_o)
  );

  sdr_ref_seq #(.NUM_AREF(NUM_AREF), .TRC_CYCLES(TRC_CYCLES)) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (ref_pend_o),
    .busy_i  (xfer_busy_i),
    .issue_o (aref_w),
    .done_o  (done_w)
  );

  assign cmd_w      = aref_w ? CMD_AREF : CMD_NOP;
  assign sd_cs_n_o  = cmd_w.cs_n;
  assign sd_ras_n_o = cmd_w.ras_n;
  assign sd_cas_n_o = cmd_w.cas_n;
  assign sd_we_n_o  = cmd_w.we_n;
  assign ref_done_o = done_w;
endmodule

// File: rtl/sdr_ref_chk.sv
module sdr_ref_chk #(
  parameter int unsigned TRC_CYCLES = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic init_done_i,
  input logic xfer_busy_i,
  input logic ref_pend_o,
  input logic aref_w,
  input logic trig_w,
  input logic ref_done_o
);
  localparam int unsigned SW = $clog2(TRC_CYCLES + 1);
  logic [SW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_q <= SW'(TRC_CYCLES);
    else if (aref_w)                 since_q <= SW'(1);
    else if (since_q < SW'(TRC_CYCLES)) since_q <= since_q + 1'b1;
  end

  a_r6_trc_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aref_w |-> since_q >= SW'(TRC_CYCLES));

  a_r5_no_aref_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aref_w |-> $past(!xfer_busy_i) || $past(aref_w) == 1'b0 && !$past(xfer_busy_i));

  a_r6_aref_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aref_w |-> ref_pend_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);

  a_r7_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o && !trig_w |=> !ref_pend_o);

  a_r3_pend_needs_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_pend_o) |-> $past(init_done_i));
endmodule

bind sdr_refresh_sched sdr_ref_chk #(.TRC_CYCLES(TRC_CYCLES)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_done_i (init_done_i),
  .xfer_busy_i (xfer_busy_i),
  .ref_pend_o  (ref_pend_o),
  .aref_w      (aref_w),
  .trig_w      (trig_w),
  .ref_done_o  (ref_done_o)
);

// File: tb/sdr_refresh_sched_tb_top.sv
module sdr_refresh_sched_tb_top;
  localparam int LIM  = 770;
  localparam int NREF = 2;
  localparam int TRC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, man = 1'b0, busy = 1'b0;
  logic pend, cs_n, ras_n, cas_n, we_n, done;

  always #10 clk = ~clk;

  sdr_refresh_sched #(.TIMER_CYCLES(LIM), .NUM_AREF(NREF), .TRC_CYCLES(TRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init), .manual_req_i(man),
    .xfer_busy_i(busy), .ref_pend_o(pend), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n),
    .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .ref_done_o(done)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  // cycle model built from the requirements
  int m_tmr = 0, m_pos = -1;
  bit m_pend = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr = 0; m_pos = -1; m_pend = 1'b0;
    end else begin
      bit fire, last;
      fire  = init && (man || m_tmr == LIM - 1);
      m_tmr = (!init || fire) ? 0 : m_tmr + 1;
      last  = (m_pos == NREF * TRC);
      if (m_pos < 0) begin
        if (m_pend && !busy) m_pos = 0;
      end else if (last) m_pos = -1;
      else m_pos = m_pos + 1;
      if (fire) m_pend = 1'b1;
      else if (last) m_pend = 1'b0;
    end
  end

  function automatic logic [3:0] exp_cmd(int pos);
    if (pos >= 0 && pos < NREF * TRC && pos % TRC == 0) return 4'b0001;
    return 4'b0111;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] c, e;
    c = {cs_n, ras_n, cas_n, we_n};
    e = exp_cmd(m_pos);
    chk(c == e, busy ? "R5" : "R6", "cmd", int'(c), int'(e));
    chk(done == (m_pos == NREF * TRC), "R7", "done", int'(done), int'(m_pos == NREF * TRC));
    chk(pend == m_pend, cur_tag, "pend", int'(pend), int'(m_pend));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_man();
    man = 1'b1; cyc(1); man = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    cur_tag = "R1";
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    // R3: requests before init are ignored
    cur_tag = "R3";
    repeat (5) begin pulse_man(); cyc(7); end
    cyc(900);
    chk(pend == 1'b0, "R3", "pend before init", int'(pend), 0);
    // R2: timer-driven refreshes
    cur_tag = "R2";
    init = 1'b1;
    cyc(LIM * 2 + 40);
    // R4: manual request mid-interval restarts the counter
    cur_tag = "R4";
    cyc(300);
    pulse_man();
    chk(pend == 1'b1, "R4", "pend after manual", int'(pend), 1);
    cyc(5);
    // R8: second manual during the running sequence is absorbed
    cur_tag = "R8";
    pulse_man();
    cyc(LIM + 20);
    // R5/R8: busy held across an expiry and a manual request
    cur_tag = "R5";
    busy = 1'b1;
    cyc(LIM + 10);
    cur_tag = "R8";
    pulse_man();
    cyc(LIM + 30);
    busy = 1'b0;
    cyc(60);
    // mixed random traffic
    cur_tag = "R6";
    for (int i = 0; i < 20000; i++) begin
      man = ($urandom_range(0, 299) == 0);
      if (busy) busy = ($urandom_range(0, 9) != 0);
      else if (!pend) busy = ($urandom_range(0, 5) == 0);
      cyc(1);
    end
    man = 1'b0; busy = 1'b0;
    cyc(50);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule